// File: doc/BRIEF.md
# Eight-Channel Pin Interrupt Front End

This block watches eight input lines that have already been picked from the device pins. It turns activity on each line into an interrupt request for a parent interrupt controller. Each channel can detect edges or qualify a level. In edge mode, rising and falling transitions can be armed independently. A detected transition is held pending until software acknowledges it. In level mode, the request follows the pin while the channel is enabled, and a per-channel polarity bit decides whether high or low counts as active.

Software configures the block through an APB register bank with zero wait states. Each enable register has two companion write-only aliases. Writing ones to one alias sets bits and writing ones to the other clears bits, so concurrent drivers never need a read-modify-write cycle. Two record registers capture every transition seen on each line, whatever the enables say. Each request output is a plain per-channel line that the parent samples as an edge.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, every channel is in edge mode with all enables off, and every request output is low.
- R2: Registers sit at word offsets inside the APB window, and bit i of each register belongs to channel i. The offsets are: 0x00 mode; 0x04 rise enable (read/write); 0x08 rise-enable set alias; 0x0C rise-enable clear alias; 0x10 fall enable (read/write); 0x14 fall-enable set alias; 0x18 fall-enable clear alias; 0x1C rise record; 0x20 fall record; 0x24 status.
- R3: A write of 1 to a bit of a set alias sets that enable bit, and a write of 1 to a bit of a clear alias clears it. A 0 bit leaves the enable unchanged, and both aliases read as 0.
- R4: A mode bit of 1 selects level detection for its channel and a mode bit of 0 selects edge detection. Each request output equals the channel's status bit.
- R5: In edge mode a rising transition sets the channel's status bit only if rise enable is 1, and a falling transition sets it only if fall enable is 1. Both may be armed at once.
- R6: In edge mode, writing 1 to a status bit clears it and writing 0 keeps it. If a new enabled transition arrives in the same cycle as the clear, the bit stays set.
- R7: The rise and fall record bits latch every detected transition of their kind in either mode, regardless of enables. Each record bit clears when 1 is written to it.
- R8: In level mode the status bit is 1 exactly when rise enable is 1 and the synchronised pin equals the fall-enable bit (1 = active-high, 0 = active-low). This status is not latched, and writes to it have no effect.
- R9: Each input passes through a two-flop synchroniser. A level-mode request therefore reflects a pin change after two clock edges, and an edge-mode request rises on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high, no wait states |
| chanIn | input | NUM_CH | Selected channel input lines |
| irqOut | output | NUM_CH | Per-channel interrupt request lines |

## Verification
On every cycle, the assertions check four things. The set and clear aliases must change exactly the written bits. Every synchronised rising transition must appear in the rise record. A level channel with its enable off must never request. A pending edge request may drop only after a status write or a mode change. Some behaviours only the bench scenarios can show. These are the exact cycle on which a request appears after a pin change, the outcome when a clear and a new edge meet in one cycle, the polarity choice in level mode, and the fact that status writes are ignored in level mode.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;

  typedef enum logic [3:0] {
    SEL_MODE     = 4'd0,
    SEL_RISE_EN  = 4'd1,
    SEL_RISE_SET = 4'd2,
    SEL_RISE_CLR = 4'd3,
    SEL_FALL_EN  = 4'd4,
    SEL_FALL_SET = 4'd5,
    SEL_FALL_CLR = 4'd6,
    SEL_RISE_REC = 4'd7,
    SEL_FALL_REC = 4'd8,
    SEL_STATUS   = 4'd9,
    SEL_NONE     = 4'd15
  } regSel_e;

  typedef struct packed {
    logic    wrMode;
    logic    wrRiseEn;
    logic    setRiseEn;
    logic    clrRiseEn;
    logic    wrFallEn;
    logic    setFallEn;
    logic    clrFallEn;
    logic    clrRiseRec;
    logic    clrFallRec;
    logic    clrStatus;
    regSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/pic_sync.sv
`timescale 1ns/1ps
module pic_sync #(
  parameter int NUM_CH = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] rawIn,
  output logic [NUM_CH-1:0] syncLvl,
  output logic [NUM_CH-1:0] riseEvt,
  output logic [NUM_CH-1:0] fallEvt
);
  localparam int LAST = STAGES - 1;

  logic [NUM_CH-1:0] stageQ [STAGES];
  logic [NUM_CH-1:0] prevQ;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= rawIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[g] <= '0;
          else       stageQ[g] <= stageQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= stageQ[LAST];
  end

  assign syncLvl = stageQ[LAST];
  assign riseEvt = stageQ[LAST] & ~prevQ;
  assign fallEvt = ~stageQ[LAST] & prevQ;
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output ctlStrobes_t       strobes
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = 5;

  logic    inWindow;
  logic    wrAccess;
  logic    rdAccess;
  regSel_e sel;
  logic    unusedLow;

  assign unusedLow = ^paddr[IDX_LO-1:0];
  assign inWindow  = (paddr[ADDR_W-1:IDX_HI+1] == '0);
  assign wrAccess  = psel && penable && pwrite && inWindow;
  assign rdAccess  = psel && !pwrite && inWindow;

  always_comb begin
    case (paddr[IDX_HI:IDX_LO])
      4'd0:    sel = SEL_MODE;
      4'd1:    sel = SEL_RISE_EN;
      4'd2:    sel = SEL_RISE_SET;
      4'd3:    sel = SEL_RISE_CLR;
      4'd4:    sel = SEL_FALL_EN;
      4'd5:    sel = SEL_FALL_SET;
      4'd6:    sel = SEL_FALL_CLR;
      4'd7:    sel = SEL_RISE_REC;
      4'd8:    sel = SEL_FALL_REC;
      4'd9:    sel = SEL_STATUS;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes            = '0;
    strobes.rdSel      = rdAccess ? sel : SEL_NONE;
    strobes.wrMode     = wrAccess && (sel == SEL_MODE);
    strobes.wrRiseEn   = wrAccess && (sel == SEL_RISE_EN);
    strobes.setRiseEn  = wrAccess && (sel == SEL_RISE_SET);
    strobes.clrRiseEn  = wrAccess && (sel == SEL_RISE_CLR);
    strobes.wrFallEn   = wrAccess && (sel == SEL_FALL_EN);
    strobes.setFallEn  = wrAccess && (sel == SEL_FALL_SET);
    strobes.clrFallEn  = wrAccess && (sel == SEL_FALL_CLR);
    strobes.clrRiseRec = wrAccess && (sel == SEL_RISE_REC);
    strobes.clrFallRec = wrAccess && (sel == SEL_FALL_REC);
    strobes.clrStatus  = wrAccess && (sel == SEL_STATUS);
  end
endmodule

// File: rtl/pic_datapath.sv
`timescale 1ns/1ps
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] syncLvl,
  input  logic [NUM_CH-1:0] riseEvt,
  input  logic [NUM_CH-1:0] fallEvt,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq,
  output logic [NUM_CH-1:0] modeQ,
  output logic [NUM_CH-1:0] riseEnQ,
  output logic [NUM_CH-1:0] fallEnQ,
  output logic [NUM_CH-1:0] riseRecQ
);
  logic [NUM_CH-1:0] fallRecQ;
  logic [NUM_CH-1:0] pendQ;
  logic [NUM_CH-1:0] riseEnNext;
  logic [NUM_CH-1:0] fallEnNext;
  logic [NUM_CH-1:0] pendNext;
  logic [NUM_CH-1:0] levelAct;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] rdNarrow;

  always_comb begin
    riseEnNext = riseEnQ;
    if (strobes.wrRiseEn)       riseEnNext = wdata;
    else if (strobes.setRiseEn) riseEnNext = riseEnQ | wdata;
    else if (strobes.clrRiseEn) riseEnNext = riseEnQ & ~wdata;

    fallEnNext = fallEnQ;
    if (strobes.wrFallEn)       fallEnNext = wdata;
    else if (strobes.setFallEn) fallEnNext = fallEnQ | wdata;
    else if (strobes.clrFallEn) fallEnNext = fallEnQ & ~wdata;
  end

  // Edge pending: acknowledge first, then new armed edges, so a new edge wins.
  always_comb begin
    pendNext = pendQ;
    if (strobes.clrStatus) pendNext = pendNext & ~wdata;
    pendNext = (pendNext | (riseEvt & riseEnQ) | (fallEvt & fallEnQ)) & ~modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= '0;
      riseEnQ  <= '0;
      fallEnQ  <= '0;
      riseRecQ <= '0;
      fallRecQ <= '0;
      pendQ    <= '0;
    end else begin
      if (strobes.wrMode) modeQ <= wdata;
      riseEnQ  <= riseEnNext;
      fallEnQ  <= fallEnNext;
      riseRecQ <= (riseRecQ & ~(strobes.clrRiseRec ? wdata : '0)) | riseEvt;
      fallRecQ <= (fallRecQ & ~(strobes.clrFallRec ? wdata : '0)) | fallEvt;
      pendQ    <= pendNext;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : gChan
      // Level qualify: enable from rise bit, polarity from fall bit.
      assign levelAct[c] = riseEnQ[c] && (syncLvl[c] == fallEnQ[c]);
      assign status[c]   = modeQ[c] ? levelAct[c] : pendQ[c];
    end
  endgenerate

  assign irq = status;

  always_comb begin
    case (strobes.rdSel)
      SEL_MODE:     rdNarrow = modeQ;
      SEL_RISE_EN:  rdNarrow = riseEnQ;
      SEL_FALL_EN:  rdNarrow = fallEnQ;
      SEL_RISE_REC: rdNarrow = riseRecQ;
      SEL_FALL_REC: rdNarrow = fallRecQ;
      SEL_STATUS:   rdNarrow = status;
      default:      rdNarrow = '0;
    endcase
  end

  generate
    if (DATA_W > NUM_CH) begin : gPad
      assign rdata = {{(DATA_W-NUM_CH){1'b0}}, rdNarrow};
    end else begin : gNoPad
      assign rdata = rdNarrow;
    end
  endgenerate
endmodule

// File: rtl/pin_irq_ctrl.sv
`timescale 1ns/1ps
module pin_irq_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic [NUM_CH-1:0] chanIn,
  output logic [NUM_CH-1:0] irqOut
);
  localparam int DATA_W = 32;

  ctlStrobes_t       strobes;
  logic [NUM_CH-1:0] syncLvl;
  logic [NUM_CH-1:0] riseEvt;
  logic [NUM_CH-1:0] fallEvt;
  logic [NUM_CH-1:0] modeQ;
  logic [NUM_CH-1:0] riseEnQ;
  logic [NUM_CH-1:0] fallEnQ;
  logic [NUM_CH-1:0] riseRecQ;

  generate
    if (DATA_W > NUM_CH) begin : gUnused
      logic unusedHi;
      assign unusedHi = ^pwdata[DATA_W-1:NUM_CH];
    end
  endgenerate

  assign pready = 1'b1;

  pic_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(pclk), .rstN(presetn), .rawIn(chanIn),
    .syncLvl(syncLvl), .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  pic_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .strobes(strobes)
  );

  pic_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk(pclk), .rstN(presetn), .strobes(strobes),
    .wdata(pwdata[NUM_CH-1:0]), .syncLvl(syncLvl),
    .riseEvt(riseEvt), .fallEvt(fallEvt),
    .rdata(prdata), .irq(irqOut),
    .modeQ(modeQ), .riseEnQ(riseEnQ), .fallEnQ(fallEnQ), .riseRecQ(riseRecQ)
  );
endmodule

// File: rtl/pic_checker.sv
`timescale 1ns/1ps
module pic_checker #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [NUM_CH-1:0] irq,
  input logic [NUM_CH-1:0] mode,
  input logic [NUM_CH-1:0] riseEn,
  input logic [NUM_CH-1:0] riseRec,
  input logic [NUM_CH-1:0] riseEvt
);
  logic       wrHit;
  logic [3:0] idx;

  assign wrHit = psel && penable && pwrite && (paddr[ADDR_W-1:6] == '0);
  assign idx   = paddr[5:2];

  // R3: set alias ORs the written ones into the rise enable
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && idx == 4'd2) |=> (riseEn == ($past(riseEn) | $past(pwdata[NUM_CH-1:0]))));

  // R3: clear alias removes exactly the written ones
  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && idx == 4'd3) |=> (riseEn == ($past(riseEn) & ~$past(pwdata[NUM_CH-1:0]))));

  // R8: a level channel with its enable off never requests
  assert_level_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((mode & ~riseEn & irq) == '0));

  // R6: a pending edge request only drops after a status write or mode change
  assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrHit && idx == 4'd9) |=> (($past(irq) & ~$past(mode) & ~mode & ~irq) == '0));

  // R7: every synchronised rising transition lands in the rise record
  assert_rec_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseEvt) & ~riseRec) == '0));
endmodule

bind pin_irq_ctrl pic_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .irq(irqOut), .mode(modeQ),
  .riseEn(riseEnQ), .riseRec(riseRecQ), .riseEvt(riseEvt)
);

// File: tb/sim_pin_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pin_irq_ctrl;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready;
  logic [NUM_CH-1:0] chanIn = '0;
  logic [NUM_CH-1:0] irqOut;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  bit    sampleNow = 1'b0;
  bit    done = 1'b0;
  int    compared = 0;
  int    mismatched = 0;

  always #10 clk = ~clk;

  pin_irq_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
    .pclk(clk), .presetn(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .chanIn(chanIn), .irqOut(irqOut)
  );

  // Monitor: samples 5 ns after the falling edge, well away from the rising edge.
  always begin
    @(negedge clk);
    #5;
    if (sampleNow && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.isIrq ? {{(32-NUM_CH){1'b0}}, irqOut} : prdata;
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
      sampleNow = 1'b0;
    end
  end

  task automatic apbWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    q.push_back('{1'b0, e, tag});
    sampleNow = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic expectIrq(input logic [NUM_CH-1:0] e, input string tag);
    @(negedge clk);
    q.push_back('{1'b1, {24'h0, e}, tag});
    sampleNow = 1'b1;
  endtask

  task automatic setPins(input logic [NUM_CH-1:0] v);
    @(negedge clk);
    chanIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state of every register and the request lines
    for (int i = 0; i < 10; i++) apbRead(ADDR_W'(i * 4), 32'h0, "R1 reset register");
    expectIrq(8'h00, "R1 reset irq");

    // R3: set and clear aliases, alias reads as zero
    apbWrite(12'h008, 32'h0F);
    apbRead(12'h004, 32'h0F, "R3 set alias");
    apbWrite(12'h00C, 32'h05);
    apbRead(12'h004, 32'h0A, "R3 clear alias");
    apbRead(12'h008, 32'h00, "R3 alias reads zero");
    apbWrite(12'h014, 32'h30);
    apbRead(12'h010, 32'h30, "R2 fall enable offset");

    // R5/R7: rising edges on all lines, only enabled ones pend
    setPins(8'hFF);
    apbRead(12'h024, 32'h0A, "R5 rise armed status");
    expectIrq(8'h0A, "R5 rise irq");
    apbRead(12'h01C, 32'hFF, "R7 rise record all");
    apbRead(12'h020, 32'h00, "R7 fall record empty");

    // R5: falling edges add the fall-armed channels
    setPins(8'h00);
    apbRead(12'h024, 32'h3A, "R5 fall armed status");
    apbRead(12'h020, 32'hFF, "R7 fall record all");

    // R6/R7: write-one-to-clear
    apbWrite(12'h024, 32'h0A);
    apbRead(12'h024, 32'h30, "R6 status clear");
    apbWrite(12'h01C, 32'h0F);
    apbRead(12'h01C, 32'hF0, "R7 record clear");

    // R6: clear of bit1 meets a new armed rise on bit1 in the same cycle
    @(negedge clk);
    chanIn = 8'h02;
    apbWrite(12'h024, 32'h12);
    repeat (3) @(negedge clk);
    apbRead(12'h024, 32'h22, "R6 new edge wins over clear");

    // R4/R8: level mode on channels 6 (active-high) and 7 (active-low)
    apbWrite(12'h008, 32'hC0);
    apbWrite(12'h014, 32'h40);
    apbWrite(12'h000, 32'hC0);
    apbRead(12'h000, 32'hC0, "R4 mode readback");
    apbRead(12'h024, 32'hA2, "R8 active-low level");
    expectIrq(8'hA2, "R4 irq follows status");
    setPins(8'hC2);
    apbRead(12'h024, 32'h62, "R8 active-high level");
    apbRead(12'h01C, 32'hF2, "R7 record in level mode");
    apbWrite(12'h024, 32'hC0);
    apbRead(12'h024, 32'h62, "R8 status write ignored");
    apbWrite(12'h00C, 32'h40);
    apbRead(12'h024, 32'h22, "R8 level enable off");

    // R9: synchroniser latency on an active-low level channel
    @(negedge clk);
    chanIn = 8'h42;
    expectIrq(8'h22, "R9 after one edge");
    expectIrq(8'hA2, "R9 after two edges");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule